// File: doc/BRIEF.md
# Serial Control Port and Register File for a Dual Three-Channel Scanner Front End

This block is the slave side of a three-wire control port (serial clock, chip select active low, one data line) together with the configuration registers it serves. A host frames each access with the select line low. The block decodes a direction flag, a register address, two turnaround clocks and one data byte. A write changes one register. A read turns the data line round and shifts the register contents back to the host.

Every register field is brought out as a parallel output for the analog side: power and enable bits, output format select, reference range, clamp controls, six 9-bit gain words and six 8-bit offset words. The pad is modelled as an output value `sdo` plus an enable `sdo_en`; the incoming level is `sdi`. The serial pins are resynchronised into the system clock domain, and their edges are found from the resynchronised samples.

Top module: `scan_ctl_port`

## Requirements
- R1: After reset, register 00h reads 07h, register 01h reads 00h, every gain and offset register reads 00h, and address 14h reads 50h. The outputs match these values.
- R2: A frame starts when `cs_n` falls. Bits are taken on rising `sck` edges in this order: the direction flag (0 = write, 1 = read), five address bits MSB first, two ignored turnaround bits, then eight data bits MSB first.
- R3: A write takes effect only after its eighth data bit. A frame ended by `cs_n` rising before that bit leaves every register unchanged.
- R4: On a read, `sdo_en` rises at the first falling `sck` edge after the second turnaround bit. At that edge `sdo` carries data bit 7, and bits 6 down to 0 follow on the next seven falling edges. `sdo` changes only on falling `sck` edges.
- R5: `sdo_en` stays low during write frames and during the first eight bits of a read. Once raised it stays high until `cs_n` rises, and then it drops.
- R6: Register 00h is decoded as follows: bit 0 is `pwr_on`, bit 1 is `fe1_on`, bit 2 is `fe2_on`, bit 3 is `rate_hi`, and bits 7:6 are `out_fmt`.
- R7: Register 01h is decoded as follows: bit 0 is `ref_low`, bit 1 is `clamp_dac_on`, bit 2 is `clamp_range`, bit 3 is `clamp_on`, and bits 7:4 are `clamp_level`.
- R8: The six channels are ordered R1, G1, B1, R2, G2, B2 as c = 0..5. For channel c, the gain low byte is at 02h+2c and gain bit 8 is bit 0 of 03h+2c. The 9-bit gain appears on `gain_word[9c+8:9c]`. An odd gain address reads back as {7'b0, bit 8}.
- R9: The offset of channel c is at 0Eh+c and appears on `offset_word[8c+7:8c]`.
- R10: Addresses 15h to 1Fh read as 00h and ignore writes. Address 14h is read-only and always returns 50h.
- R11: Clock edges past the sixteenth bit of a frame are ignored. Each new fall of `cs_n` starts decoding afresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sck | input | 1 | Serial clock from host |
| cs_n | input | 1 | Frame select, active low |
| sdi | input | 1 | Serial data level seen at the pad |
| sdo | output | 1 | Serial read data driven to the pad |
| sdo_en | output | 1 | Pad drive enable for sdo |
| pwr_on | output | 1 | Whole-device active (0 = powered down) |
| fe1_on | output | 1 | Front end 1 active |
| fe2_on | output | 1 | Front end 2 active |
| rate_hi | output | 1 | Higher conversion-rate select |
| out_fmt | output | 2 | Output data format select |
| ref_low | output | 1 | Reduced ADC reference range |
| clamp_dac_on | output | 1 | Clamp level DAC active |
| clamp_range | output | 1 | Clamp DAC range select |
| clamp_on | output | 1 | Line clamping enable |
| clamp_level | output | 4 | Clamp DAC level code |
| gain_word | output | 54 | Six 9-bit gains, channel c at bits 9c+8:9c |
| offset_word | output | 48 | Six 8-bit offsets, channel c at bits 8c+7:8c |

## Verification
The assertions assume that `sck`, `cs_n` and `sdi` change slowly against `clk`, so that each serial edge is seen as one clean transition after the synchroniser. They also assume that `sck` rests low whenever `cs_n` moves. The bench holds every serial half period at six system clocks and changes `sdi` and `cs_n` only while `sck` is low. It mixes directed frames with random writes, reads and aborted or over-long frames at random addresses across the whole 5-bit space.

// File: rtl/scan_ctl_pkg.sv
package scan_ctl_pkg;

    localparam int ADDR_W     = 5;
    localparam int DATA_W     = 8;
    localparam int NUM_CH     = 6;
    localparam int GAIN_W     = 9;
    localparam int OFS_W      = 8;
    localparam int DUMMY_BITS = 2;
    localparam int FRAME_BITS = 1 + ADDR_W + DUMMY_BITS + DATA_W;
    localparam int CNT_W      = $clog2(FRAME_BITS + 1);
    localparam int CH_W       = $clog2(NUM_CH);

    localparam logic [ADDR_W-1:0] ADR_SYS   = 5'h00;
    localparam logic [ADDR_W-1:0] ADR_AFE   = 5'h01;
    localparam logic [ADDR_W-1:0] ADR_GAIN0 = 5'h02;
    localparam logic [ADDR_W-1:0] ADR_OFS0  = 5'h0E;
    localparam logic [ADDR_W-1:0] ADR_RSV   = 5'h14;

    localparam logic [DATA_W-1:0] RST_SYS = 8'h07;
    localparam logic [DATA_W-1:0] RST_AFE = 8'h00;
    localparam logic [DATA_W-1:0] VAL_RSV = 8'h50;

    typedef enum logic [2:0] {
        K_SYS, K_AFE, K_GLO, K_GHI, K_OFS, K_RSV, K_NONE
    } addr_kind_t;

    typedef struct packed {
        logic              en;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } wr_req_t;

    function automatic addr_kind_t classify(input logic [ADDR_W-1:0] a);
        addr_kind_t k;
        if (a == ADR_SYS)                                  k = K_SYS;
        else if (a == ADR_AFE)                             k = K_AFE;
        else if (a >= ADR_GAIN0 && a < ADR_OFS0)           k = a[0] ? K_GHI : K_GLO;
        else if (a >= ADR_OFS0 && a < ADR_OFS0 + NUM_CH)   k = K_OFS;
        else if (a == ADR_RSV)                             k = K_RSV;
        else                                               k = K_NONE;
        return k;
    endfunction

    function automatic logic [CH_W-1:0] gain_chan(input logic [ADDR_W-1:0] a);
        logic [ADDR_W-1:0] d;
        d = a - ADR_GAIN0;
        return d[CH_W:1];
    endfunction

    function automatic logic [CH_W-1:0] ofs_chan(input logic [ADDR_W-1:0] a);
        logic [ADDR_W-1:0] d;
        d = a - ADR_OFS0;
        return d[CH_W-1:0];
    endfunction

endpackage

// File: rtl/scan_ctl_sync.sv
module scan_ctl_sync #(
    parameter int              W      = 3,
    parameter int              STAGES = 2,
    parameter logic [W-1:0]    RST_V  = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst)        chain[s] <= RST_V;
                else if (s == 0) chain[s] <= d;
                else            chain[s] <= chain[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/scan_ctl_frame.sv
module scan_ctl_frame
    import scan_ctl_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  sck_s,
    input  logic                  cs_n_s,
    input  logic                  sdi_s,
    input  logic [DATA_W-1:0]     rd_byte,
    output logic [ADDR_W-1:0]     cur_addr,
    output wr_req_t               wr,
    output logic                  sdo,
    output logic                  sdo_en,
    output logic                  sck_fall,
    output logic [CNT_W-1:0]      bit_cnt
);
    localparam logic [CNT_W-1:0] LAST_HDR = CNT_W'(1 + ADDR_W + DUMMY_BITS);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_BITS - 1);
    localparam logic [CNT_W-1:0] FULL     = CNT_W'(FRAME_BITS);

    logic              sck_prev;
    logic              sck_rise;
    logic              is_read;
    logic [DATA_W-2:0] data_sh;
    logic [DATA_W-2:0] out_sh;
    logic              active;

    assign sck_rise = sck_s & ~sck_prev;
    assign sck_fall = ~sck_s & sck_prev;
    assign active   = ~cs_n_s;

    always_ff @(posedge clk) begin
        if (rst) sck_prev <= 1'b0;
        else     sck_prev <= sck_s;
    end

    // Header and data capture on rising serial edges.
    always_ff @(posedge clk) begin
        if (rst || !active) begin
            bit_cnt  <= '0;
            is_read  <= 1'b0;
            cur_addr <= '0;
            data_sh  <= '0;
        end else if (sck_rise && bit_cnt < FULL) begin
            bit_cnt <= bit_cnt + 1'b1;
            if (bit_cnt == '0)
                is_read <= sdi_s;
            else if (bit_cnt <= CNT_W'(ADDR_W))
                cur_addr <= {cur_addr[ADDR_W-2:0], sdi_s};
            else if (bit_cnt >= LAST_HDR)
                data_sh <= {data_sh[DATA_W-3:0], sdi_s};
        end
    end

    // Write request: one clock pulse on the last data bit of a write frame.
    always_ff @(posedge clk) begin
        if (rst) begin
            wr <= '0;
        end else begin
            wr.en   <= active && sck_rise && bit_cnt == LAST_BIT && !is_read;
            wr.addr <= cur_addr;
            wr.data <= {data_sh, sdi_s};
        end
    end

    // Read shifter: launches on falling serial edges.
    always_ff @(posedge clk) begin
        if (rst) begin
            sdo_en <= 1'b0;
            sdo    <= 1'b0;
            out_sh <= '0;
        end else if (!active) begin
            sdo_en <= 1'b0;
        end else if (sck_fall) begin
            if (is_read && !sdo_en && bit_cnt == LAST_HDR) begin
                sdo_en <= 1'b1;
                sdo    <= rd_byte[DATA_W-1];
                out_sh <= rd_byte[DATA_W-2:0];
            end else if (sdo_en && bit_cnt > LAST_HDR && bit_cnt < FULL) begin
                sdo    <= out_sh[DATA_W-2];
                out_sh <= {out_sh[DATA_W-3:0], 1'b0};
            end
        end
    end
endmodule

// File: rtl/scan_ctl_regs.sv
module scan_ctl_regs
    import scan_ctl_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  wr_req_t                  wr,
    input  logic [ADDR_W-1:0]        rd_addr,
    output logic [DATA_W-1:0]        rd_byte,
    output logic [DATA_W-1:0]        sys_reg,
    output logic [DATA_W-1:0]        afe_reg,
    output logic [NUM_CH*GAIN_W-1:0] gain_word,
    output logic [NUM_CH*OFS_W-1:0]  offset_word
);
    addr_kind_t      wkind;
    logic [CH_W-1:0] wgch;
    logic [CH_W-1:0] woch;

    logic [DATA_W-1:0] lo_arr  [NUM_CH];
    logic              hi_arr  [NUM_CH];
    logic [OFS_W-1:0]  ofs_arr [NUM_CH];

    assign wkind = classify(wr.addr);
    assign wgch  = gain_chan(wr.addr);
    assign woch  = ofs_chan(wr.addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            sys_reg <= RST_SYS;
            afe_reg <= RST_AFE;
        end else if (wr.en) begin
            if (wkind == K_SYS) sys_reg <= wr.data;
            if (wkind == K_AFE) afe_reg <= wr.data;
        end
    end

    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
            logic [DATA_W-1:0] lo;
            logic              hi;
            logic [OFS_W-1:0]  ofs;

            always_ff @(posedge clk) begin
                if (rst) begin
                    lo  <= '0;
                    hi  <= 1'b0;
                    ofs <= '0;
                end else if (wr.en) begin
                    if (wkind == K_GLO && wgch == CH_W'(c)) lo  <= wr.data;
                    if (wkind == K_GHI && wgch == CH_W'(c)) hi  <= wr.data[0];
                    if (wkind == K_OFS && woch == CH_W'(c)) ofs <= wr.data;
                end
            end

            assign lo_arr[c]  = lo;
            assign hi_arr[c]  = hi;
            assign ofs_arr[c] = ofs;
            assign gain_word[c*GAIN_W +: GAIN_W] = {hi, lo};
            assign offset_word[c*OFS_W +: OFS_W] = ofs;
        end
    endgenerate

    always_comb begin
        rd_byte = '0;
        unique case (classify(rd_addr))
            K_SYS:  rd_byte = sys_reg;
            K_AFE:  rd_byte = afe_reg;
            K_GLO:  rd_byte = lo_arr[gain_chan(rd_addr)];
            K_GHI:  rd_byte = {{(DATA_W-1){1'b0}}, hi_arr[gain_chan(rd_addr)]};
            K_OFS:  rd_byte = ofs_arr[ofs_chan(rd_addr)];
            K_RSV:  rd_byte = VAL_RSV;
            default: rd_byte = '0;
        endcase
    end
endmodule

// File: rtl/scan_ctl_port.sv
module scan_ctl_port
    import scan_ctl_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        sck,
    input  logic        cs_n,
    input  logic        sdi,
    output logic        sdo,
    output logic        sdo_en,
    output logic        pwr_on,
    output logic        fe1_on,
    output logic        fe2_on,
    output logic        rate_hi,
    output logic [1:0]  out_fmt,
    output logic        ref_low,
    output logic        clamp_dac_on,
    output logic        clamp_range,
    output logic        clamp_on,
    output logic [3:0]  clamp_level,
    output logic [53:0] gain_word,
    output logic [47:0] offset_word
);
    logic [2:0]        pins_s;
    logic              sck_s, cs_n_s, sdi_s;
    logic [ADDR_W-1:0] cur_addr;
    logic [DATA_W-1:0] rd_byte;
    logic [DATA_W-1:0] sys_reg, afe_reg;
    wr_req_t           wr;
    logic              sck_fall;
    logic [CNT_W-1:0]  bit_cnt;

    scan_ctl_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_V(3'b010)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({sck, cs_n, sdi}),
        .q   (pins_s)
    );
    assign {sck_s, cs_n_s, sdi_s} = pins_s;

    scan_ctl_frame u_frame (
        .clk      (clk),
        .rst      (rst),
        .sck_s    (sck_s),
        .cs_n_s   (cs_n_s),
        .sdi_s    (sdi_s),
        .rd_byte  (rd_byte),
        .cur_addr (cur_addr),
        .wr       (wr),
        .sdo      (sdo),
        .sdo_en   (sdo_en),
        .sck_fall (sck_fall),
        .bit_cnt  (bit_cnt)
    );

    scan_ctl_regs u_regs (
        .clk         (clk),
        .rst         (rst),
        .wr          (wr),
        .rd_addr     (cur_addr),
        .rd_byte     (rd_byte),
        .sys_reg     (sys_reg),
        .afe_reg     (afe_reg),
        .gain_word   (gain_word),
        .offset_word (offset_word)
    );

    assign pwr_on       = sys_reg[0];
    assign fe1_on       = sys_reg[1];
    assign fe2_on       = sys_reg[2];
    assign rate_hi      = sys_reg[3];
    assign out_fmt      = sys_reg[7:6];
    assign ref_low      = afe_reg[0];
    assign clamp_dac_on = afe_reg[1];
    assign clamp_range  = afe_reg[2];
    assign clamp_on     = afe_reg[3];
    assign clamp_level  = afe_reg[7:4];
endmodule

// File: rtl/scan_ctl_port_chk.sv
module scan_ctl_port_chk
    import scan_ctl_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              cs_n_s,
    input logic              sck_fall,
    input logic [CNT_W-1:0]  bit_cnt,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              sdo,
    input logic              sdo_en,
    input logic [7:0]        sys_reg,
    input logic [7:0]        afe_reg,
    input logic [53:0]       gain_word,
    input logic [47:0]       offset_word
);
    AST_OE_DROPS_ON_DESELECT: assert property (@(posedge clk) disable iff (rst)
        cs_n_s |=> !sdo_en);  // R5

    AST_NO_DRIVE_IN_WRITE: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> !sdo_en);  // R5

    AST_SDO_ONLY_ON_FALL: assert property (@(posedge clk) disable iff (rst)
        !sck_fall |=> $stable(sdo));  // R4

    AST_REGS_HOLD_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> ($stable(sys_reg) && $stable(afe_reg)
                    && $stable(gain_word) && $stable(offset_word)));  // R3

    AST_UNDEF_WRITE_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr >= ADR_RSV) |=> ($stable(sys_reg) && $stable(afe_reg)
                    && $stable(gain_word) && $stable(offset_word)));  // R10

    AST_BIT_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        bit_cnt <= CNT_W'(FRAME_BITS));  // R11
endmodule

bind scan_ctl_port scan_ctl_port_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .cs_n_s      (cs_n_s),
    .sck_fall    (sck_fall),
    .bit_cnt     (bit_cnt),
    .wr_en       (wr.en),
    .wr_addr     (wr.addr),
    .sdo         (sdo),
    .sdo_en      (sdo_en),
    .sys_reg     (sys_reg),
    .afe_reg     (afe_reg),
    .gain_word   (gain_word),
    .offset_word (offset_word)
);

// File: tb/scan_ctl_port_tb.sv
module scan_ctl_port_tb;
    localparam int HALF = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sck = 1'b0, cs_n = 1'b1, sdi = 1'b0;
    logic sdo, sdo_en, pwr_on, fe1_on, fe2_on, rate_hi, ref_low;
    logic clamp_dac_on, clamp_range, clamp_on;
    logic [1:0]  out_fmt;
    logic [3:0]  clamp_level;
    logic [53:0] gain_word;
    logic [47:0] offset_word;

    int n_tests = 0, n_fail = 0;
    bit done = 0;
    logic [7:0] mdl [32];

    always #5 clk = ~clk;

    scan_ctl_port u_dut (
        .clk(clk), .rst(rst), .sck(sck), .cs_n(cs_n), .sdi(sdi),
        .sdo(sdo), .sdo_en(sdo_en), .pwr_on(pwr_on), .fe1_on(fe1_on),
        .fe2_on(fe2_on), .rate_hi(rate_hi), .out_fmt(out_fmt),
        .ref_low(ref_low), .clamp_dac_on(clamp_dac_on),
        .clamp_range(clamp_range), .clamp_on(clamp_on),
        .clamp_level(clamp_level), .gain_word(gain_word),
        .offset_word(offset_word)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_read(input logic [4:0] a);
        if (a == 5'h14) return 8'h50;
        if (a > 5'h14)  return 8'h00;
        return mdl[a];
    endfunction

    function automatic void mdl_write(input logic [4:0] a, input logic [7:0] d);
        if (a >= 5'h14) return;
        if (a >= 5'h02 && a <= 5'h0D && a[0]) mdl[a] = {7'b0, d[0]};
        else mdl[a] = d;
    endfunction

    function automatic logic [53:0] exp_gain();
        logic [53:0] g;
        for (int c = 0; c < 6; c++) g[c*9 +: 9] = {mdl[3+2*c][0], mdl[2+2*c]};
        return g;
    endfunction

    function automatic logic [47:0] exp_ofs();
        logic [47:0] o;
        for (int c = 0; c < 6; c++) o[c*8 +: 8] = mdl[14+c];
        return o;
    endfunction

    function automatic bit frame_bit(input bit rw, input logic [4:0] a,
                                     input logic [7:0] d, input int i);
        if (i == 0) return rw;
        if (i <= 5) return a[5-i];
        if (i <= 7) return 1'b0;
        if (i <= 15) return d[15-i];
        return 1'b1;
    endfunction

    task automatic check_outputs(input string tag);
        logic [7:0] s, f;
        s = {out_fmt, mdl[0][5:4], rate_hi, fe2_on, fe1_on, pwr_on};
        f = {clamp_level, clamp_on, clamp_range, clamp_dac_on, ref_low};
        check({out_fmt, rate_hi, fe2_on, fe1_on, pwr_on} ==
              {mdl[0][7:6], mdl[0][3:0]}, "R6", {tag, " sys fields"}, s, mdl[0]);
        check(f == mdl[1], "R7", {tag, " clamp fields"}, f, mdl[1]);
        check(gain_word == exp_gain(), "R8", {tag, " gain words"}, gain_word, exp_gain());
        check(offset_word == exp_ofs(), "R9", {tag, " offset words"}, offset_word, exp_ofs());
    endtask

    // R2 frame: flag, address, two turnaround bits, data; nbits may cut or extend it
    task automatic frame(input bit rw, input logic [4:0] a, input logic [7:0] d,
                         input int nbits, output logic [7:0] got);
        bit oe_bad = 0;
        got = '0;
        @(negedge clk);
        sck = 1'b0; cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            sdi = frame_bit(rw, a, d, i);
            repeat (HALF) @(negedge clk);
            if (rw && i >= 8 && i <= 15) begin
                got[15-i] = sdo;
                if (sdo_en !== 1'b1) oe_bad = 1;
            end else if (i <= 15 && sdo_en !== 1'b0) oe_bad = 1;
            sck = 1'b1;
            repeat (HALF) @(negedge clk);
            sck = 1'b0;
        end
        repeat (HALF) @(negedge clk);
        check(!oe_bad, "R5", "sdo_en during frame", oe_bad, 0);
        cs_n = 1'b1; sdi = 1'b0;
        repeat (HALF) @(negedge clk);
        check(sdo_en === 1'b0, "R5", "sdo_en after deselect", sdo_en, 0);
    endtask

    task automatic do_write(input logic [4:0] a, input logic [7:0] d);
        logic [7:0] g;
        frame(1'b0, a, d, 16, g);
        mdl_write(a, d);
    endtask

    task automatic do_read(input logic [4:0] a, input string req);
        logic [7:0] g;
        frame(1'b1, a, 8'h00, 16, g);
        check(g == exp_read(a), req, $sformatf("R2/R4 read addr %0h", a), g, exp_read(a));
    endtask

    initial begin
        logic [7:0] g;
        void'($urandom(32'h5CA1_0F1E));
        for (int i = 0; i < 32; i++) mdl[i] = 8'h00;
        mdl[0] = 8'h07;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);

        // R1 reset state
        check(sdo_en === 1'b0, "R1", "sdo_en at reset", sdo_en, 0);
        check_outputs("R1 reset");
        do_read(5'h00, "R1");
        do_read(5'h14, "R1");
        do_read(5'h0D, "R1");

        // R6 / R7 field decode
        do_write(5'h00, 8'hC8); check_outputs("R6 write sys");
        do_read(5'h00, "R6");
        do_write(5'h01, 8'hA5); check_outputs("R7 write afe");

        // R8 gain split across two addresses
        do_write(5'h08, 8'h3C);
        do_write(5'h09, 8'hFF);
        check(gain_word[27 +: 9] == 9'h13C, "R8", "gain ch3", gain_word[27 +: 9], 9'h13C);
        do_read(5'h09, "R8");

        // R9 offset
        do_write(5'h13, 8'h9D);
        check(offset_word[40 +: 8] == 8'h9D, "R9", "offset ch5", offset_word[40 +: 8], 8'h9D);

        // R10 undefined and reserved
        do_write(5'h1A, 8'h77); check_outputs("R10 undef write");
        do_read(5'h1A, "R10");
        do_write(5'h14, 8'h12); do_read(5'h14, "R10");

        // R3 aborted write
        frame(1'b0, 5'h0E, 8'hFF, 15, g);
        check_outputs("R3 abort");
        do_read(5'h0E, "R3");

        // R11 over-long frame commits once, extra edges ignored
        frame(1'b0, 5'h10, 8'h5A, 21, g);
        mdl_write(5'h10, 8'h5A);
        check_outputs("R11 long frame");
        do_read(5'h10, "R11");

        // random mix
        for (int k = 0; k < 120; k++) begin
            logic [4:0] a;
            logic [7:0] d;
            int kind;
            a = 5'($urandom_range(0, 31));
            d = 8'($urandom);
            kind = $urandom_range(0, 9);
            if (kind < 5) do_write(a, d);
            else if (kind < 8) do_read(a, "R2");
            else begin
                frame(1'b0, a, d, $urandom_range(1, 15), g);
                check_outputs("R3 random abort");
            end
            if (k % 10 == 0) check_outputs("R2 random");
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL R11 watchdog actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule